// File: doc/BRIEF.md
# Indexed configuration port target

This block is the configuration-space end point of a peripheral controller that is reached through a two-byte I/O window. The host writes a register number to the index port at offset 0 and then reads or writes the selected register through the data port at offset 1. The index register keeps its value between accesses, so a run of data-port accesses keeps hitting the same register.

The block is closed after reset. The host opens it by writing the opening key 0x87 to the index port on two consecutive writes, and closes it again by writing 0xAA to the index port. Registers below 0x30 are global: a logical-device number, a read-only 16-bit chip ID, a multi-function select and a global option register. Registers from 0x30 upward are banked. The logical-device number picks which bank the data port reaches.

Every banked register is also driven out on a flat bus so that the functional units can use their settings. The three pin-group availability flags are decoded from the two global select registers.

Top module: `cfgport_target`

## Requirements
- R1: After reset the block is closed. Both ports read 0xFF, the multi-function select holds 0x0C, the option register holds 0x04, all three availability flags are 0 and every banked register is 0x00.
- R2: The block opens only after two consecutive writes of 0x87 to the index port. Any other write between them, to either port, restarts the sequence. While the block is not open, an index write of any other value leaves it closed.
- R3: While the block is not open, data-port writes change no register and reads of either port return 0xFF.
- R4: An index-port write of 0xAA while open closes the block. The key writes 0x87 and 0xAA never change the stored index, so the index survives a close and reopen.
- R5: While open, an index-port read returns the stored index. Repeated data-port reads and writes all address that same register.
- R6: Register 0x20 reads 0x10 and register 0x21 reads 0x61, the two halves of the ID 0x1061. Writes to either register are discarded.
- R7: Register 0x07 is a read/write logical-device number that stores any 8-bit value. Registers 0x30 to 0x30+DEV_REGS-1 address the bank of the device that register 0x07 selects, for devices 0 to NUM_DEV-1. Register k of device d appears on dev_regs bits [(d*DEV_REGS+k)*8 +: 8].
- R8: Register 0x1C is read/write. bank0_free is the inverse of its bit 3 and bank1_free is the inverse of its bit 2.
- R9: Register 0x27 is read/write. pin_bank_free is 1 only when bit 4 of 0x1C is set and bit 2 of 0x27 is clear.
- R10: Unimplemented registers read 0x00 and discard writes. This covers unused global numbers, banked offsets at DEV_REGS or above, and any banked access while the device number is NUM_DEV or more.
- R11: When a data-port read and a data-port write fall in the same cycle, the read returns the value held before the write, and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| io_addr | input | 1 | Window offset: 0 index port, 1 data port |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe, sampled at the rising edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data while io_rd is high, 0x00 otherwise |
| dev_regs | output | NUM_DEV*DEV_REGS*8 | All banked registers, flattened |
| bank0_free | output | 1 | First eight-pin group released from its other function |
| bank1_free | output | 1 | Second eight-pin group released from its other function |
| pin_bank_free | output | 1 | Single-pin group available |

## Verification
Two functions can meet in one cycle: a data-port read and a data-port write to the same register, when the host raises both strobes together. The bench provokes this on the logical-device register. It expects the read to return the previous device number and a following plain read to return the new one. A second overlap is a key write that arrives while the sequence is half done. The bench judges it by whether the data port still reads 0xFF after the next opening key.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
   typedef enum logic [1:0] {
      KS_SHUT = 2'd0,
      KS_HALF = 2'd1,
      KS_OPEN = 2'd2
   } key_state_e;

   localparam logic [7:0] KEY_OPEN    = 8'h87;
   localparam logic [7:0] KEY_SHUT    = 8'hAA;
   localparam logic [7:0] IDX_LDN     = 8'h07;
   localparam logic [7:0] IDX_MFSEL   = 8'h1C;
   localparam logic [7:0] IDX_ID_HI   = 8'h20;
   localparam logic [7:0] IDX_ID_LO   = 8'h21;
   localparam logic [7:0] IDX_GOPT    = 8'h27;
   localparam logic [7:0] IDX_DEVBASE = 8'h30;
   localparam logic [7:0] SHUT_READ   = 8'hFF;
endpackage

// File: rtl/cfgport_key.sv
module cfgport_key
   import cfgport_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_idx,
   input  logic       wr_dat,
   input  logic [7:0] wdata,
   output logic       unlocked,
   output logic       idx_load
);
   key_state_e st, st_nxt;

   always_comb begin
      st_nxt = st;
      case (st)
         KS_SHUT: if (wr_idx && wdata == KEY_OPEN) st_nxt = KS_HALF;
         KS_HALF: begin
            if (wr_idx && wdata == KEY_OPEN)  st_nxt = KS_OPEN;
            else if (wr_idx || wr_dat)        st_nxt = KS_SHUT;
         end
         KS_OPEN: if (wr_idx && wdata == KEY_SHUT) st_nxt = KS_SHUT;
         default: st_nxt = KS_SHUT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= KS_SHUT;
      else        st <= st_nxt;
   end

   assign unlocked = (st == KS_OPEN);
   assign idx_load = unlocked && wr_idx && (wdata != KEY_SHUT) && (wdata != KEY_OPEN);

   // R2
   no_skip_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == KS_SHUT) |=> (st != KS_OPEN));

   // R4
   shut_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (unlocked && wr_idx && wdata == KEY_SHUT) |=> !unlocked);
endmodule

// File: rtl/cfgport_globals.sv
module cfgport_globals
   import cfgport_pkg::*;
#(
   parameter logic [15:0] ID_VALUE  = 16'h1061,
   parameter logic [7:0]  MF_RESET  = 8'h0C,
   parameter logic [7:0]  OPT_RESET = 8'h04
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] index,
   input  logic [7:0] wdata,
   output logic [7:0] ldn,
   output logic [7:0] mfsel,
   output logic [7:0] gopt,
   output logic [7:0] rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ldn   <= 8'h00;
         mfsel <= MF_RESET;
         gopt  <= OPT_RESET;
      end else if (wr_en) begin
         if (index == IDX_LDN)   ldn   <= wdata;
         if (index == IDX_MFSEL) mfsel <= wdata;
         if (index == IDX_GOPT)  gopt  <= wdata;
      end
   end

   always_comb begin
      case (index)
         IDX_LDN:   rdata = ldn;
         IDX_MFSEL: rdata = mfsel;
         IDX_ID_HI: rdata = ID_VALUE[15:8];
         IDX_ID_LO: rdata = ID_VALUE[7:0];
         IDX_GOPT:  rdata = gopt;
         default:   rdata = 8'h00;
      endcase
   end

   // R3
   closed_ldn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ldn) && $stable(mfsel) && $stable(gopt));

   // R7
   ldn_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && index == IDX_LDN) |=> (ldn == $past(wdata)));
endmodule

// File: rtl/cfgport_devbank.sv
module cfgport_devbank
   import cfgport_pkg::*;
#(
   parameter int NUM_DEV  = 16,
   parameter int DEV_REGS = 4,
   localparam int FLAT_W  = NUM_DEV * DEV_REGS * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        ldn,
   input  logic [7:0]        index,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic [FLAT_W-1:0] regs_flat
);
   initial begin
      assert (NUM_DEV >= 1 && NUM_DEV <= 256)
         else $error("NUM_DEV out of range");
      assert (DEV_REGS >= 1 && DEV_REGS <= 208)
         else $error("DEV_REGS out of range");
   end

   logic [7:0] off;
   logic       in_win;
   logic       dev_ok;
   logic [7:0] store [NUM_DEV][DEV_REGS];

   assign off    = index - IDX_DEVBASE;
   assign in_win = (index >= IDX_DEVBASE) && (int'(off) < DEV_REGS);
   assign dev_ok = int'(ldn) < NUM_DEV;

   for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
      for (genvar k = 0; k < DEV_REGS; k++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               store[d][k] <= 8'h00;
            else if (wr_en && in_win && dev_ok && ldn == 8'(d) && off == 8'(k))
               store[d][k] <= wdata;
         end
         assign regs_flat[(d*DEV_REGS+k)*8 +: 8] = store[d][k];
      end
   end

   always_comb begin
      rdata = 8'h00;
      for (int d = 0; d < NUM_DEV; d++)
         for (int k = 0; k < DEV_REGS; k++)
            if (in_win && ldn == 8'(d) && off == 8'(k))
               rdata = store[d][k];
   end

   // R3
   closed_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(regs_flat));

   // R10
   unimpl_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !(in_win && dev_ok)) |=> $stable(regs_flat));
endmodule

// File: rtl/cfgport_target.sv
module cfgport_target
   import cfgport_pkg::*;
#(
   parameter int          NUM_DEV   = 16,
   parameter int          DEV_REGS  = 4,
   parameter logic [15:0] ID_VALUE  = 16'h1061,
   parameter logic [7:0]  MF_RESET  = 8'h0C,
   parameter logic [7:0]  OPT_RESET = 8'h04,
   localparam int         FLAT_W    = NUM_DEV * DEV_REGS * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_addr,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   output logic [FLAT_W-1:0] dev_regs,
   output logic              bank0_free,
   output logic              bank1_free,
   output logic              pin_bank_free
);
   logic       wr_idx, wr_dat, unlocked, idx_load, dat_wen, glob_hit;
   logic [7:0] index, ldn, mfsel, gopt, glob_rdata, dev_rdata, sel_rdata;

   assign wr_idx = io_wr && !io_addr;
   assign wr_dat = io_wr && io_addr;

   cfgport_key u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_idx   (wr_idx),
      .wr_dat   (wr_dat),
      .wdata    (io_wdata),
      .unlocked (unlocked),
      .idx_load (idx_load)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        index <= 8'h00;
      else if (idx_load) index <= io_wdata;
   end

   assign dat_wen  = unlocked && wr_dat;
   assign glob_hit = index < IDX_DEVBASE;

   cfgport_globals #(
      .ID_VALUE  (ID_VALUE),
      .MF_RESET  (MF_RESET),
      .OPT_RESET (OPT_RESET)
   ) u_glob (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (dat_wen && glob_hit),
      .index (index),
      .wdata (io_wdata),
      .ldn   (ldn),
      .mfsel (mfsel),
      .gopt  (gopt),
      .rdata (glob_rdata)
   );

   cfgport_devbank #(
      .NUM_DEV  (NUM_DEV),
      .DEV_REGS (DEV_REGS)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (dat_wen && !glob_hit),
      .ldn       (ldn),
      .index     (index),
      .wdata     (io_wdata),
      .rdata     (dev_rdata),
      .regs_flat (dev_regs)
   );

   always_comb begin
      if (!unlocked)     sel_rdata = SHUT_READ;
      else if (!io_addr) sel_rdata = index;
      else if (glob_hit) sel_rdata = glob_rdata;
      else               sel_rdata = dev_rdata;
   end

   assign io_rdata      = io_rd ? sel_rdata : 8'h00;
   assign bank0_free    = !mfsel[3];
   assign bank1_free    = !mfsel[2];
   assign pin_bank_free = mfsel[4] && !gopt[2];

   // R3
   closed_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && io_rd) |-> (io_rdata == SHUT_READ));

   // R5
   index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !io_wr |=> $stable(index));
endmodule

// File: tb/cfgport_target_bench.sv
module cfgport_target_bench;
   localparam int NUM_DEV  = 16;
   localparam int DEV_REGS = 4;
   localparam int FLAT_W   = NUM_DEV * DEV_REGS * 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              io_addr = 1'b0, io_rd = 1'b0, io_wr = 1'b0;
   logic [7:0]        io_wdata = 8'h00;
   logic [7:0]        io_rdata;
   logic [FLAT_W-1:0] dev_regs;
   logic              bank0_free, bank1_free, pin_bank_free;
   int                tests = 0, fails = 0;

   always #10 clk = ~clk;

   cfgport_target #(.NUM_DEV(NUM_DEV), .DEV_REGS(DEV_REGS)) u_cfgport_target (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_regs(dev_regs),
      .bank0_free(bank0_free), .bank1_free(bank1_free), .pin_bank_free(pin_bank_free)
   );

   // vector: {is_read, addr, data, expected, requirement number}
   localparam int NV = 50;
   localparam logic [21:0] VEC [NV] = '{
      {1'b0,1'b0,8'h20,8'h00,4'd6}, {1'b1,1'b1,8'h00,8'h10,4'd6},   // R6 ID high
      {1'b0,1'b0,8'h21,8'h00,4'd6}, {1'b1,1'b1,8'h00,8'h61,4'd6},   // R6 ID low
      {1'b0,1'b1,8'hFF,8'h00,4'd6}, {1'b1,1'b1,8'h00,8'h61,4'd6},   // R6 write dropped
      {1'b1,1'b1,8'h00,8'h61,4'd5},                                  // R5 repeat read
      {1'b0,1'b0,8'h07,8'h00,4'd7}, {1'b0,1'b1,8'h03,8'h00,4'd7},
      {1'b1,1'b1,8'h00,8'h03,4'd7}, {1'b1,1'b0,8'h00,8'h07,4'd5},   // R7, R5 index read
      {1'b0,1'b0,8'h30,8'h00,4'd7}, {1'b0,1'b1,8'hA5,8'h00,4'd7},
      {1'b1,1'b1,8'h00,8'hA5,4'd7},
      {1'b0,1'b0,8'h31,8'h00,4'd7}, {1'b0,1'b1,8'h5A,8'h00,4'd7},
      {1'b1,1'b1,8'h00,8'h5A,4'd7},
      {1'b0,1'b0,8'h07,8'h00,4'd7}, {1'b0,1'b1,8'h04,8'h00,4'd7},   // R7 switch bank
      {1'b0,1'b0,8'h30,8'h00,4'd7}, {1'b1,1'b1,8'h00,8'h00,4'd7},
      {1'b0,1'b1,8'hC3,8'h00,4'd7}, {1'b1,1'b1,8'h00,8'hC3,4'd7},
      {1'b0,1'b0,8'h07,8'h00,4'd7}, {1'b0,1'b1,8'h03,8'h00,4'd7},
      {1'b0,1'b0,8'h30,8'h00,4'd7}, {1'b1,1'b1,8'h00,8'hA5,4'd7},
      {1'b0,1'b0,8'h34,8'h00,4'd10},{1'b0,1'b1,8'h77,8'h00,4'd10},  // R10 offset past end
      {1'b1,1'b1,8'h00,8'h00,4'd10},
      {1'b0,1'b0,8'h07,8'h00,4'd10},{1'b0,1'b1,8'h10,8'h00,4'd10},  // R10 device 16
      {1'b0,1'b0,8'h30,8'h00,4'd10},{1'b0,1'b1,8'h99,8'h00,4'd10},
      {1'b1,1'b1,8'h00,8'h00,4'd10},
      {1'b0,1'b0,8'h07,8'h00,4'd7}, {1'b1,1'b1,8'h00,8'h10,4'd7},
      {1'b0,1'b0,8'h40,8'h00,4'd10},{1'b0,1'b1,8'h11,8'h00,4'd10},
      {1'b1,1'b1,8'h00,8'h00,4'd10},
      {1'b0,1'b0,8'h00,8'h00,4'd10},{1'b0,1'b1,8'h22,8'h00,4'd10},  // R10 global gap
      {1'b1,1'b1,8'h00,8'h00,4'd10},
      {1'b0,1'b0,8'h1C,8'h00,4'd8}, {1'b1,1'b1,8'h00,8'h0C,4'd8},   // R8 reset value
      {1'b0,1'b0,8'h27,8'h00,4'd9}, {1'b1,1'b1,8'h00,8'h04,4'd9},   // R9 reset value
      {1'b0,1'b0,8'h07,8'h00,4'd7}, {1'b0,1'b1,8'h03,8'h00,4'd7},
      {1'b1,1'b1,8'h00,8'h03,4'd7}
   };

   task automatic check(input logic [FLAT_W-1:0] act, input logic [FLAT_W-1:0] exp,
                        input string req);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] v);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #5 v = io_rdata;
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic rd_chk(input logic a, input logic [7:0] exp, input string req);
      logic [7:0] v;
      rd(a, v);
      check(FLAT_W'(v), FLAT_W'(exp), req);
   endtask

   task automatic flags_chk(input logic [2:0] exp, input string req);
      check(FLAT_W'({bank0_free, bank1_free, pin_bank_free}), FLAT_W'(exp), req);
   endtask

   initial begin
      #4_000_000;
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [FLAT_W-1:0] exp_flat;
      logic [7:0]        v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd_chk(1'b1, 8'hFF, "R1 data port closed");
      rd_chk(1'b0, 8'hFF, "R1 index port closed");
      flags_chk(3'b000, "R1 flags");
      check(dev_regs, '0, "R1 banked regs");
      // R2 broken sequences
      wr(1'b0, 8'h87); wr(1'b0, 8'h12); wr(1'b0, 8'h87);
      rd_chk(1'b1, 8'hFF, "R2 index write between keys");
      wr(1'b0, 8'hAA); wr(1'b0, 8'h87); wr(1'b1, 8'h01); wr(1'b0, 8'h87);
      rd_chk(1'b1, 8'hFF, "R2 data write between keys");
      wr(1'b0, 8'h87);
      rd_chk(1'b0, 8'h00, "R2 open after two keys, R4 index kept");
      // table walk
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][21]) begin
            rd(VEC[i][20], v);
            check(FLAT_W'(v), FLAT_W'(VEC[i][11:4]), $sformatf("R%0d vec %0d", VEC[i][3:0], i));
         end else begin
            wr(VEC[i][20], VEC[i][19:12]);
         end
      end
      // R7 banked registers on the flat bus
      exp_flat = '0;
      exp_flat[(3*DEV_REGS+0)*8 +: 8] = 8'hA5;
      exp_flat[(3*DEV_REGS+1)*8 +: 8] = 8'h5A;
      exp_flat[(4*DEV_REGS+0)*8 +: 8] = 8'hC3;
      check(dev_regs, exp_flat, "R7 R10 flat bus");
      // R8 R9 flags
      wr(1'b0, 8'h1C); wr(1'b1, 8'h00);
      flags_chk(3'b110, "R8 both banks free");
      wr(1'b1, 8'h10);
      flags_chk(3'b110, "R9 option bit blocks pin");
      wr(1'b0, 8'h27); wr(1'b1, 8'h00);
      flags_chk(3'b111, "R9 pin free");
      wr(1'b0, 8'h1C); wr(1'b1, 8'h18);
      wr(1'b0, 8'h27); wr(1'b1, 8'hFB);
      flags_chk(3'b011, "R8 R9 mixed");
      // R11 read and write together
      wr(1'b0, 8'h07);
      @(negedge clk);
      io_addr = 1'b1; io_wdata = 8'h05; io_rd = 1'b1; io_wr = 1'b1;
      #5 v = io_rdata;
      @(negedge clk);
      io_rd = 1'b0; io_wr = 1'b0;
      check(FLAT_W'(v), FLAT_W'(8'h03), "R11 old value returned");
      rd_chk(1'b1, 8'h05, "R11 write landed");
      // R4 close, R3 ignored write
      wr(1'b0, 8'hAA);
      rd_chk(1'b1, 8'hFF, "R4 closed by key");
      wr(1'b1, 8'h09);
      wr(1'b0, 8'h87); wr(1'b0, 8'h87);
      rd_chk(1'b0, 8'h07, "R4 index survives close");
      rd_chk(1'b1, 8'h05, "R3 closed write ignored");
      check(dev_regs, exp_flat, "R3 banks untouched");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule